// File: doc/BRIEF.md
# Multi-Address I2C Register Slave

This block is a slave-only I2C target. It lets an external bus master read and write registers inside the chip. SCL and SDA are oversampled by a fast system clock. From those samples the block finds START, repeated START and STOP conditions. It shifts address and data bytes, acknowledges by pulling SDA low, and otherwise leaves the line released. The block never drives SCL and never starts a transfer.

One instance answers on a bank of consecutive 7-bit addresses, by default the four from 0x48 to 0x4B. It reports which of them was matched as a page index, and the register side uses that index to pick one of several register pages. A second instance built with a bank size of one answers on a single address set by a parameter. After the address, the first byte of a write sets an internal register pointer. Every later byte written or read moves that pointer forward by one. The block also recognises the master code that announces a high-speed transfer. It flags high-speed mode until the next STOP, so the bus can run with SCL high times down to 60 ns.

Top module: `i2c_bank_slave`

## Requirements
- R1: With defaults (base 0x48, four addresses), an address byte carrying 7-bit address 0x48, 0x49, 0x4A or 0x4B is acknowledged: `sda_drive_low_o` is 1 during the ninth SCL high phase.
- R2: Addresses 0x47 and 0x4C get no acknowledge, and the data bytes that follow until the next START produce no `reg_wr_o` pulse and no acknowledge.
- R3: An instance with bank size 1 and base 0x12 acknowledges only address 0x12. The default instance does not acknowledge 0x12, and the single instance does not acknowledge 0x48.
- R4: `sda_drive_low_o` is 0 out of reset, in the cycle after any START or STOP, and while no transaction is selected. It is asserted only for an acknowledge or for a 0 data bit being read.
- R5: `page_o` equals the matched address minus the base (0x49 gives 1, 0x4B gives 3). It is 0 after reset and changes only when an address is accepted.
- R6: In a write, the first data byte loads the pointer and is not written. Each later byte gives one `reg_wr_o` pulse with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte, and the pointer then increments. Every data byte is acknowledged.
- R7: In a read, each byte is taken from `reg_rdata_i` in the cycle `reg_rd_o` pulses, at address `reg_addr_o`. The byte is sent MSB first and the pointer then increments. A master NACK ends the read and releases SDA.
- R8: A byte of the form 00001xxx in the address position is not acknowledged, and it sets `hs_mode_o` to 1.
- R9: `hs_mode_o` stays 1 through a repeated START and returns to 0 only at a STOP.
- R10: A repeated START restarts address decoding, keeps the pointer, and allows a combined write-pointer-then-read transfer.
- R11: With a 250 MHz clock, transfers with SCL high for 15 clocks (60 ns) and low for 40 clocks (160 ns) are received and acknowledged correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| hs_mode_o | output | 1 | High-speed mode active |
| page_o | output | PAGE_W | Index of matched address within the bank |
| reg_addr_o | output | REG_AW | Register pointer |
| reg_wdata_o | output | 8 | Byte to write |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe; rdata sampled this cycle |
| reg_rdata_i | input | 8 | Register read data for `reg_addr_o` |

## Verification
The hardest state to reach from the ports is high-speed operation. It needs a non-acknowledged master code, then a repeated START with no STOP in between, and then bit timing near the oversampling limit. The bench sends the master code at normal speed and then narrows the SCL phases to 15 and 40 clocks. Under those phases it issues a repeated START and a full write, checking the mode flag before and after the closing STOP. The combined pointer-write and read through a repeated START is driven the same way, to show that the pointer survives the restart.

// File: rtl/i2c_bank_pkg.sv
package i2c_bank_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WRX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bank_st_t;

   localparam int BYTE_W = 8;

   function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
      return (b[7:3] == 5'b00001);
   endfunction
endpackage

// File: rtl/i2c_bank_line_fe.sv
module i2c_bank_line_fe #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] scl_pipe, sda_pipe;
   logic         scl_q, sda_q;
   logic         scl_n, sda_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
         sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
         scl_q    <= scl_pipe[TOP];
         sda_q    <= sda_pipe[TOP];
      end
   end

   assign scl_n      = scl_pipe[TOP];
   assign sda_n      = sda_pipe[TOP];
   assign sda_o      = sda_n;
   assign scl_rise_o = scl_n & ~scl_q;
   assign scl_fall_o = ~scl_n & scl_q;
   assign start_o    = scl_n & scl_q & sda_q & ~sda_n;
   assign stop_o     = scl_n & scl_q & ~sda_q & sda_n;
endmodule

// File: rtl/i2c_bank_addr_match.sv
module i2c_bank_addr_match #(
   parameter int BASE_ADDR  = 'h48,
   parameter int ADDR_COUNT = 4,
   parameter int PAGE_W     = 2
) (
   input  logic [6:0]        addr_i,
   output logic              hit_o,
   output logic [PAGE_W-1:0] idx_o
);
   if (ADDR_COUNT == 1) begin : g_one
      assign hit_o = (addr_i == 7'(BASE_ADDR));
      assign idx_o = '0;
   end else begin : g_bank
      logic [ADDR_COUNT-1:0] lane;
      for (genvar i = 0; i < ADDR_COUNT; i++) begin : g_lane
         assign lane[i] = (addr_i == 7'(BASE_ADDR + i));
      end
      always_comb begin
         idx_o = '0;
         for (int j = 0; j < ADDR_COUNT; j++)
            if (lane[j]) idx_o = PAGE_W'(j);
      end
      assign hit_o = |lane;
   end
endmodule

// File: rtl/i2c_bank_engine.sv
module i2c_bank_engine
   import i2c_bank_pkg::*;
#(
   parameter int PAGE_W = 2,
   parameter int REG_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              hit_i,
   input  logic [PAGE_W-1:0] hit_idx_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic [6:0]        addr_o,
   output logic              sda_low_o,
   output logic              hs_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [REG_AW-1:0] ptr_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              wr_o,
   output logic              rd_o,
   output logic              match_o,
   output bank_st_t          st_o
);
   bank_st_t          st;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic [3:0]        cnt;
   logic              rd_mode, first_byte, mack_ok;
   logic              rd_take;

   assign rd_take = scl_fall_i & ~start_i & ~stop_i &
                    (((st == ST_ACK) & rd_mode) | ((st == ST_MACK) & mack_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         rx_sh      <= '0;
         tx_sh      <= '0;
         cnt        <= '0;
         rd_mode    <= 1'b0;
         first_byte <= 1'b0;
         mack_ok    <= 1'b0;
         sda_low_o  <= 1'b0;
         hs_o       <= 1'b0;
         page_o     <= '0;
         ptr_o      <= '0;
         wdata_o    <= '0;
         wr_o       <= 1'b0;
         match_o    <= 1'b0;
      end else begin
         wr_o    <= 1'b0;
         match_o <= 1'b0;
         if (wr_o) ptr_o <= ptr_o + 1'b1;
         if (stop_i) begin
            st        <= ST_IDLE;
            sda_low_o <= 1'b0;
            hs_o      <= 1'b0;
         end else if (start_i) begin
            st        <= ST_ADDR;
            cnt       <= '0;
            sda_low_o <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: ;
               ST_ADDR, ST_WRX: begin
                  if (scl_rise_i) begin
                     rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall_i && cnt == 4'd8) begin
                     if (st == ST_ADDR) begin
                        if (hit_i) begin
                           sda_low_o  <= 1'b1;
                           st         <= ST_ACK;
                           rd_mode    <= rx_sh[0];
                           first_byte <= 1'b1;
                           page_o     <= hit_idx_i;
                           match_o    <= 1'b1;
                        end else begin
                           if (is_master_code(rx_sh)) hs_o <= 1'b1;
                           st <= ST_IDLE;
                        end
                     end else begin
                        sda_low_o <= 1'b1;
                        st        <= ST_ACK;
                        if (first_byte) begin
                           ptr_o      <= rx_sh[REG_AW-1:0];
                           first_byte <= 1'b0;
                        end else begin
                           wdata_o <= rx_sh;
                           wr_o    <= 1'b1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (rd_take) begin
                     tx_sh     <= rdata_i;
                     sda_low_o <= ~rdata_i[BYTE_W-1];
                     ptr_o     <= ptr_o + 1'b1;
                     cnt       <= '0;
                     st        <= ST_TX;
                  end else if (scl_fall_i) begin
                     sda_low_o <= 1'b0;
                     cnt       <= '0;
                     st        <= ST_WRX;
                  end
               end
               ST_TX: begin
                  if (scl_fall_i) begin
                     if (cnt == 4'd7) begin
                        sda_low_o <= 1'b0;
                        st        <= ST_MACK;
                     end else begin
                        tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                        sda_low_o <= ~tx_sh[BYTE_W-2];
                        cnt       <= cnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise_i) begin
                     mack_ok <= ~sda_i;
                  end else if (rd_take) begin
                     tx_sh     <= rdata_i;
                     sda_low_o <= ~rdata_i[BYTE_W-1];
                     ptr_o     <= ptr_o + 1'b1;
                     cnt       <= '0;
                     st        <= ST_TX;
                  end else if (scl_fall_i) begin
                     st <= ST_IDLE;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assign addr_o = rx_sh[BYTE_W-1:1];
   assign rd_o   = rd_take;
   assign st_o   = st;
endmodule

// File: rtl/i2c_bank_slave.sv
module i2c_bank_slave
   import i2c_bank_pkg::*;
#(
   parameter int BASE_ADDR   = 'h48,
   parameter int ADDR_COUNT  = 4,
   parameter int REG_AW      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SYS_CLK_MHZ = 250,
   parameter int PAGE_W      = (ADDR_COUNT > 1) ? $clog2(ADDR_COUNT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low_o,
   output logic              hs_mode_o,
   output logic [PAGE_W-1:0] page_o,
   output logic [REG_AW-1:0] reg_addr_o,
   output logic [7:0]        reg_wdata_o,
   output logic              reg_wr_o,
   output logic              reg_rd_o,
   input  logic [7:0]        reg_rdata_i
);
   localparam int HS_HIGH_NS  = 60;
   localparam int HIGH_CLOCKS = (SYS_CLK_MHZ * HS_HIGH_NS) / 1000;

   if (ADDR_COUNT < 1 || BASE_ADDR + ADDR_COUNT > 128) begin : g_bad_bank
      $error("address bank does not fit the 7-bit space");
   end
   if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
      $error("register pointer must be 1 to 8 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages are needed");
   end
   if (HIGH_CLOCKS < SYNC_STAGES + 2) begin : g_bad_clk
      $error("system clock too slow for the shortest high-speed SCL high time");
   end

   logic        sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic        hit, match_take;
   logic [PAGE_W-1:0] hit_idx;
   logic [6:0]  addr_field;
   bank_st_t    st;

   i2c_bank_line_fe #(.SYNC_STAGES(SYNC_STAGES)) u_fe (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   i2c_bank_addr_match #(
      .BASE_ADDR  (BASE_ADDR),
      .ADDR_COUNT (ADDR_COUNT),
      .PAGE_W     (PAGE_W)
   ) u_match (
      .addr_i (addr_field),
      .hit_o  (hit),
      .idx_o  (hit_idx)
   );

   i2c_bank_engine #(.PAGE_W(PAGE_W), .REG_AW(REG_AW)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_i      (sda_s),
      .scl_rise_i (scl_rise),
      .scl_fall_i (scl_fall),
      .start_i    (start_det),
      .stop_i     (stop_det),
      .hit_i      (hit),
      .hit_idx_i  (hit_idx),
      .rdata_i    (reg_rdata_i),
      .addr_o     (addr_field),
      .sda_low_o  (sda_drive_low_o),
      .hs_o       (hs_mode_o),
      .page_o     (page_o),
      .ptr_o      (reg_addr_o),
      .wdata_o    (reg_wdata_o),
      .wr_o       (reg_wr_o),
      .rd_o       (reg_rd_o),
      .match_o    (match_take),
      .st_o       (st)
   );
endmodule

// File: rtl/i2c_bank_slave_chk.sv
module i2c_bank_slave_chk
   import i2c_bank_pkg::*;
#(
   parameter int PAGE_W = 2,
   parameter int REG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_drive_low_o,
   input logic              hs_mode_o,
   input logic [PAGE_W-1:0] page_o,
   input logic [REG_AW-1:0] reg_addr_o,
   input logic              reg_wr_o,
   input logic              reg_rd_o,
   input logic              start_det,
   input logic              stop_det,
   input logic              match_take,
   input bank_st_t          st
);
   a_r4_release_at_cond: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_drive_low_o);

   a_r4_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_drive_low_o);

   a_r5_page_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (page_o != $past(page_o)) |-> match_take);

   a_r6_ptr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));

   a_r7_ptr_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1));

   a_r9_hs_ends_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_mode_o) |-> $past(stop_det));

   a_r9_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_mode_o && stop_det) |=> !hs_mode_o);
endmodule

bind i2c_bank_slave i2c_bank_slave_chk #(.PAGE_W(PAGE_W), .REG_AW(REG_AW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .sda_drive_low_o (sda_drive_low_o),
   .hs_mode_o       (hs_mode_o),
   .page_o          (page_o),
   .reg_addr_o      (reg_addr_o),
   .reg_wr_o        (reg_wr_o),
   .reg_rd_o        (reg_rd_o),
   .start_det       (start_det),
   .stop_det        (stop_det),
   .match_take      (match_take),
   .st              (st)
);

// File: tb/i2c_bank_slave_bench.sv
`timescale 1ns/1ps
module i2c_bank_slave_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   always #2 clk = ~clk;

   logic       drv_main, drv_single, hs_main, hs_single;
   logic [1:0] page;
   logic [0:0] page_single;
   logic [7:0] raddr, wdata, rdata, raddr_s, wdata_s;
   logic       wr, rd, wr_s, rd_s;
   wire        sda_line = sda_m & ~drv_main & ~drv_single;

   assign rdata = raddr ^ {page, 6'b0} ^ 8'h3C;

   i2c_bank_slave u_i2c_bank_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_drive_low_o(drv_main), .hs_mode_o(hs_main), .page_o(page),
      .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_wr_o(wr), .reg_rd_o(rd),
      .reg_rdata_i(rdata));

   i2c_bank_slave #(.BASE_ADDR('h12), .ADDR_COUNT(1)) u_single (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_drive_low_o(drv_single), .hs_mode_o(hs_single), .page_o(page_single),
      .reg_addr_o(raddr_s), .reg_wdata_o(wdata_s), .reg_wr_o(wr_s), .reg_rd_o(rd_s),
      .reg_rdata_i(8'h00));

   int n_chk = 0, n_fail = 0, wr_cnt = 0;
   logic [7:0] log_a [0:31];
   logic [7:0] log_d [0:31];
   int tlo = 40, thi = 30;
   logic ack_m, ack_s;
   bit done = 0;

   always @(negedge clk) if (wr) begin
      log_a[wr_cnt % 32] <= raddr;
      log_d[wr_cnt % 32] <= wdata;
      wr_cnt <= wr_cnt + 1;
   end

   function automatic logic [7:0] reg_val(logic [7:0] a, logic [1:0] p);
      return a ^ {p, 6'b0} ^ 8'h3C;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse(output logic smp);
      tick(tlo - tlo / 2);
      scl = 1'b1;
      tick(thi / 2);
      smp = sda_line; ack_m = drv_main; ack_s = drv_single;
      tick(thi - thi / 2);
      scl = 1'b0;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; scl = 1'b1; tick(thi);
      sda_m = 1'b0; tick(thi);
      scl = 1'b0;
   endtask

   task automatic bus_rstart();
      tick(tlo / 2); sda_m = 1'b1; tick(tlo - tlo / 2);
      scl = 1'b1; tick(thi);
      sda_m = 1'b0; tick(thi);
      scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(tlo / 2); sda_m = 1'b0; tick(tlo - tlo / 2);
      scl = 1'b1; tick(thi);
      sda_m = 1'b1; tick(thi);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         tick(tlo / 2); sda_m = b[i]; pulse(s);
      end
      tick(tlo / 2); sda_m = 1'b1; pulse(s);
      acked = ~s;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      logic s;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         tick(tlo / 2); sda_m = 1'b1; pulse(s);
         b = {b[6:0], s};
      end
      tick(tlo / 2); sda_m = nack; pulse(s);
   endtask

   task automatic t_reset();
      chk("R4 reset release", drv_main, 0);
      chk("R9 reset hs", hs_main, 0);
      chk("R5 reset page", page, 0);
      chk("R6 reset no write", wr, 0);
   endtask

   task automatic t_write();
      logic a;
      int base = wr_cnt;
      bus_start();
      send_byte(8'h92, a); chk("R1 ack 0x49", a, 1);
      send_byte(8'h10, a); chk("R6 pointer ack", a, 1);
      send_byte(8'h5A, a); chk("R6 data ack", a, 1);
      send_byte(8'h6B, a); chk("R6 data ack 2", a, 1);
      bus_stop();
      chk("R6 write count", wr_cnt - base, 2);
      chk("R6 first addr", log_a[base % 32], 8'h10);
      chk("R6 first data", log_d[base % 32], 8'h5A);
      chk("R6 second addr", log_a[(base + 1) % 32], 8'h11);
      chk("R6 second data", log_d[(base + 1) % 32], 8'h6B);
      chk("R5 page for 0x49", page, 1);
   endtask

   task automatic t_read_rs();
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'h96, a); chk("R1 ack 0x4B", a, 1);
      send_byte(8'h20, a); chk("R10 pointer ack", a, 1);
      bus_rstart();
      send_byte(8'h97, a); chk("R10 read address ack", a, 1);
      recv_byte(1'b0, b); chk("R7 first byte", b, reg_val(8'h20, 2'd3));
      recv_byte(1'b1, b); chk("R7 second byte", b, reg_val(8'h21, 2'd3));
      tick(tlo / 2);
      chk("R7 released after nack", drv_main, 0);
      bus_stop();
      chk("R4 released after stop", drv_main, 0);
      chk("R5 page for 0x4B", page, 3);
   endtask

   task automatic t_bank();
      logic a;
      int base;
      for (int ad = 'h47; ad <= 'h4C; ad++) begin
         bus_start();
         send_byte(8'(ad << 1), a);
         chk((ad >= 'h48 && ad <= 'h4B) ? "R1 bank ack" : "R2 outside nack",
             a, (ad >= 'h48 && ad <= 'h4B) ? 1 : 0);
         if (ad == 'h4C) begin
            base = wr_cnt;
            send_byte(8'h01, a); chk("R2 ignored byte nack", a, 0);
            send_byte(8'h77, a); chk("R2 ignored data nack", a, 0);
            chk("R2 no write", wr_cnt - base, 0);
            chk("R5 page held", page, 3);
         end
         bus_stop();
      end
   endtask

   task automatic t_single();
      logic a;
      bus_start(); send_byte(8'h24, a);
      chk("R3 single acks 0x12", ack_s, 1);
      chk("R3 bank ignores 0x12", ack_m, 0);
      bus_stop();
      bus_start(); send_byte(8'h26, a);
      chk("R3 0x13 nack", a, 0);
      bus_stop();
      bus_start(); send_byte(8'h90, a);
      chk("R3 single ignores 0x48", ack_s, 0);
      bus_stop();
   endtask

   task automatic t_hs();
      logic a;
      int base;
      bus_start();
      send_byte(8'h0D, a); chk("R8 master code nack", a, 0);
      chk("R8 hs entered", hs_main, 1);
      thi = 15; tlo = 40;
      base = wr_cnt;
      bus_rstart();
      chk("R9 hs kept over restart", hs_main, 1);
      send_byte(8'h94, a); chk("R11 fast address ack", a, 1);
      send_byte(8'h30, a); chk("R11 fast pointer ack", a, 1);
      send_byte(8'hC3, a); chk("R11 fast data ack", a, 1);
      chk("R11 fast write addr", log_a[base % 32], 8'h30);
      chk("R11 fast write data", log_d[base % 32], 8'hC3);
      chk("R5 page for 0x4A", page, 2);
      bus_stop();
      chk("R9 hs cleared at stop", hs_main, 0);
      thi = 30; tlo = 40;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_write();
      t_read_rs();
      t_bank();
      t_single();
      t_hs();
      tick(20);
      finish_run();
   end
endmodule